// File: doc/BRIEF.md
# CRC Error Counter Setup Sequencer

This block is a bus master that prepares and samples a hardware error counter for a PCI Express link. It drives a byte-wide memory-mapped configuration port, which carries an address, separate read and write strobes, write data, read data and a wait signal. One start pulse makes it run a fixed program. It first turns on CRC checking. It then selects which error event is counted, either link-level CRC failures or end-to-end CRC failures, and enables the counter, optionally clearing it at the same time. Last, it fetches the 32-bit count one byte at a time.

Every byte it programs is changed by read-modify-write. The block reads the byte, replaces only its own field, and writes the merged byte back. The link width is a build parameter, and it chooses which register bank holds the counter controls. The wait input applies back-pressure to every transfer: while it is high, the block holds its address, strobes and write data unchanged. A read completes in the cycle in which the read strobe is high and the wait input is low, and the read data is taken in that same cycle. The count output stays stable between runs. A single-cycle done pulse marks the moment the count becomes valid.

Top module: `crc_errcnt_seq`

## Requirements
- R1: After reset, busy, done, cfg_read and cfg_write are 0 and count is 0.
- R2: A run writes, in this order, to 0x119, BASE+3, BASE+2, BASE+1 and BASE+0. It then reads BASE+4, BASE+5, BASE+6 and BASE+7. BASE is 0x36C when LANES=16, 0x32C when LANES=8 and 0x2D4 when LANES=4.
- R3: The byte written to 0x119 is the byte read from 0x119 with bit 0 forced to 1 and bits 7:1 unchanged.
- R4: With sel_ecrc=0, BASE+3 receives 0x02 and BASE+2 receives 0x01. With sel_ecrc=1, BASE+3 receives 0x03 and BASE+2 receives 0x02. BASE+1 always receives 0x00. Both inputs are sampled at the accepted start.
- R5: Every write is preceded by a completed read of the same address, and no other transfer comes between them.
- R6: The byte written to BASE+0 has bits 4:2 = 3'b111 and bits 7:5 unchanged from the byte read. With clr_req=1 at start, bits 1:0 are 2'b11. Otherwise bits 1:0 keep their read value.
- R7: The count is assembled with the byte read from BASE+4 as count[7:0], BASE+5 as [15:8], BASE+6 as [23:16] and BASE+7 as [31:24]. The count is cleared when a start is accepted.
- R8: While cfg_waitreq is high during a transfer, cfg_read, cfg_write, cfg_addr and cfg_wdata hold their values. cfg_read and cfg_write are never high together.
- R9: done is high for exactly one cycle, in the cycle after the fourth count byte is taken. busy is high from the cycle after an accepted start through the done cycle.
- R10: A start pulse that arrives while busy is high has no effect. No extra transfers occur, and the sel_ecrc and clr_req values latched at the first start stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| sel_ecrc | input | 1 | 0: count link CRC errors, 1: count end-to-end CRC errors |
| clr_req | input | 1 | Clear the counters while enabling them |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle strobe when count is valid |
| count | output | 32 | Assembled error count |
| cfg_addr | output | 32 | Configuration port byte address |
| cfg_read | output | 1 | Read strobe |
| cfg_write | output | 1 | Write strobe |
| cfg_wdata | output | 8 | Write data |
| cfg_rdata | input | 8 | Read data, valid when cfg_read=1 and cfg_waitreq=0 |
| cfg_waitreq | input | 1 | Target stall; holds the current transfer |

## Verification
The main sequence is run for both counter selections. Each run uses its own prefilled byte values, so the merged write data shows whether the block keeps the bits outside each field or overwrites them. One run asks for a clear and one does not, which tells apart the two encodings of the low bits at BASE+0. Three instances are built, one per link width, and each target holds a different count. A bank-address mistake or a byte-lane swap therefore shows up as a wrong address or a wrong count. The target inserts varying stall lengths of zero to two cycles, and a second start is sent in the middle of a run, to expose transfers that are not held steady under back-pressure and a start that is not ignored while busy.

// File: rtl/crc_errcnt_pkg.sv
package crc_errcnt_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 32;
  localparam int COUNT_W   = 32;
  localparam int N_BYTES   = COUNT_W / DATA_W;
  localparam int N_RMW     = 5;
  localparam int N_STEPS   = N_RMW + N_BYTES;
  localparam int STEP_W    = $clog2(N_STEPS);
  localparam int LANE_W    = $clog2(N_BYTES);
  localparam logic [ADDR_W-1:0] CHK_ADDR = 32'h0000_0119;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} seq_state_t;

  function automatic logic [ADDR_W-1:0] bank_base(input int lanes);
    case (lanes)
      16:      return 32'h0000_036C;
      8:       return 32'h0000_032C;
      default: return 32'h0000_02D4;
    endcase
  endfunction
endpackage

// File: rtl/crc_errcnt_steps.sv
module crc_errcnt_steps
  import crc_errcnt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 32'h0000_036C
) (
  input  logic [STEP_W-1:0] idx,
  input  logic              sel_ecrc,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] value,
  output logic              is_rmw,
  output logic              is_last,
  output logic [LANE_W-1:0] lane
);
  logic [STEP_W-1:0] rd_off;
  assign rd_off  = idx - STEP_W'(N_RMW);
  assign lane    = rd_off[LANE_W-1:0];
  assign is_rmw  = (idx < STEP_W'(N_RMW));
  assign is_last = (idx == STEP_W'(N_STEPS - 1));

  always_comb begin
    addr  = BASE + ADDR_W'(N_RMW - 1) + ADDR_W'(rd_off);
    mask  = '0;
    value = '0;
    case (idx)
      STEP_W'(0): begin addr = CHK_ADDR;        mask = 8'h01; value = 8'h01; end
      STEP_W'(1): begin addr = BASE + 32'd3;    mask = 8'hFF; value = sel_ecrc ? 8'h03 : 8'h02; end
      STEP_W'(2): begin addr = BASE + 32'd2;    mask = 8'hFF; value = sel_ecrc ? 8'h02 : 8'h01; end
      STEP_W'(3): begin addr = BASE + 32'd1;    mask = 8'hFF; value = 8'h00; end
      STEP_W'(4): begin
        addr  = BASE;
        mask  = clr ? 8'h1F : 8'h1C;
        value = clr ? 8'h1F : 8'h1C;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/crc_errcnt_assemble.sv
module crc_errcnt_assemble
  import crc_errcnt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap_en,
  input  logic [LANE_W-1:0]  lane,
  input  logic [DATA_W-1:0]  din,
  output logic [COUNT_W-1:0] count
);
  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                        q <= '0;
      else if (cap_en && lane == LANE_W'(g))    q <= din;
    end
    assign count[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/crc_errcnt_seq.sv
module crc_errcnt_seq
  import crc_errcnt_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sel_ecrc,
  input  logic               clr_req,
  output logic               busy,
  output logic               done,
  output logic [COUNT_W-1:0] count,
  output logic [ADDR_W-1:0]  cfg_addr,
  output logic               cfg_read,
  output logic               cfg_write,
  output logic [DATA_W-1:0]  cfg_wdata,
  input  logic [DATA_W-1:0]  cfg_rdata,
  input  logic               cfg_waitreq
);
  localparam logic [ADDR_W-1:0] BASE = bank_base(LANES);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic              sel_q, clr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] mask, value;
  logic              is_rmw, is_last;
  logic [LANE_W-1:0] lane;
  logic              accept, take;

  crc_errcnt_steps #(.BASE(BASE)) u_steps (
    .idx(step), .sel_ecrc(sel_q), .clr(clr_q), .addr(cfg_addr),
    .mask(mask), .value(value), .is_rmw(is_rmw), .is_last(is_last), .lane(lane)
  );

  assign accept = (state == S_IDLE) && start;
  assign take   = (state == S_RD) && !cfg_waitreq && !is_rmw;

  crc_errcnt_assemble u_asm (
    .clk(clk), .rst_n(rst_n), .clr(accept), .cap_en(take),
    .lane(lane), .din(cfg_rdata), .count(count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= '0;
      sel_q   <= 1'b0;
      clr_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          sel_q <= sel_ecrc;
          clr_q <= clr_req;
          step  <= '0;
          state <= S_RD;
        end
        S_RD: if (!cfg_waitreq) begin
          if (is_rmw) begin
            wdata_q <= (cfg_rdata & ~mask) | (value & mask);
            state   <= S_WR;
          end else if (is_last) begin
            state <= S_DONE;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_WR: if (!cfg_waitreq) begin
          step  <= step + 1'b1;
          state <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfg_read  = (state == S_RD);
  assign cfg_write = (state == S_WR);
  assign cfg_wdata = wdata_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_read || cfg_write) && cfg_waitreq |=>
      cfg_read == $past(cfg_read) && cfg_write == $past(cfg_write) &&
      $stable(cfg_addr) && $stable(cfg_wdata));
  // R8
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_read && cfg_write));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R6
  en_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write && cfg_addr == BASE |-> cfg_wdata[4:2] == 3'b111);
  // R5
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_write) |-> $past(cfg_read) && $stable(cfg_addr));
endmodule

// File: tb/crc_cfg_model.sv
module crc_cfg_model (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_read,
  input  logic        cfg_write,
  input  logic [31:0] cfg_addr,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic        cfg_waitreq,
  input  logic        pre_en,
  input  logic [31:0] pre_addr,
  input  logic [7:0]  pre_data,
  input  logic        log_clr
);
  logic [7:0]  mem [0:1023];
  logic [31:0] wr_addr [0:15];
  logic [7:0]  wr_data [0:15];
  logic [31:0] rd_addr [0:15];
  int          wr_n, rd_n, rmw_err, stab_err, hold, need;
  logic [31:0] last_rd, p_addr;
  logic        last_was_rd, p_wait, p_r, p_w;
  logic [7:0]  p_d;
  logic        cmd, acc;

  assign cmd         = cfg_read || cfg_write;
  assign cfg_waitreq = cmd && (hold < need);
  assign acc         = cmd && !cfg_waitreq;
  assign cfg_rdata   = cfg_read ? mem[cfg_addr[9:0]] : 8'h00;

  always_ff @(posedge clk) begin
    if (pre_en) mem[pre_addr[9:0]] <= pre_data;
    if (!rst_n) begin
      hold <= 0; need <= 1; p_wait <= 1'b0; last_was_rd <= 1'b0; last_rd <= '0;
      wr_n <= 0; rd_n <= 0; rmw_err <= 0; stab_err <= 0;
      p_r <= 1'b0; p_w <= 1'b0; p_addr <= '0; p_d <= '0;
    end else begin
      p_wait <= cfg_waitreq; p_r <= cfg_read; p_w <= cfg_write;
      p_addr <= cfg_addr; p_d <= cfg_wdata;
      if (p_wait && (cfg_read != p_r || cfg_write != p_w ||
                     cfg_addr != p_addr || cfg_wdata != p_d))
        stab_err <= stab_err + 1;
      if (acc) begin
        hold <= 0;
        need <= (need + 1) % 3;
      end else if (cmd) hold <= hold + 1;
      if (log_clr) begin
        wr_n <= 0; rd_n <= 0; rmw_err <= 0; stab_err <= 0;
      end else if (acc && cfg_write) begin
        mem[cfg_addr[9:0]] <= cfg_wdata;
        if (wr_n < 16) begin
          wr_addr[wr_n] <= cfg_addr;
          wr_data[wr_n] <= cfg_wdata;
        end
        wr_n <= wr_n + 1;
        if (!last_was_rd || last_rd != cfg_addr) rmw_err <= rmw_err + 1;
        last_was_rd <= 1'b0;
      end else if (acc && cfg_read) begin
        if (rd_n < 16) rd_addr[rd_n] <= cfg_addr;
        rd_n <= rd_n + 1;
        last_rd <= cfg_addr;
        last_was_rd <= 1'b1;
      end
    end
  end
endmodule

// File: tb/crc_errcnt_seq_bench.sv
module crc_errcnt_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, sel = 1'b0, clr = 1'b0;
  logic pre_en = 1'b0, log_clr = 1'b0;
  logic [31:0] pre_addr = '0;
  logic [7:0]  pre_data = '0;
  int checks = 0, errors = 0;
  int dn16 = 0, dn8 = 0, dn4 = 0;

  localparam logic [31:0] B16 = 32'h36C, B8 = 32'h32C, B4 = 32'h2D4;

  logic b16, d16, r16, w16, wt16, b8, d8, r8, w8, wt8, b4, d4, r4, w4, wt4;
  logic [31:0] c16, a16, c8, a8, c4, a4;
  logic [7:0]  wd16, rd16, wd8, rd8, wd4, rd4;

  crc_errcnt_seq #(.LANES(16)) u_crc_errcnt_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_ecrc(sel), .clr_req(clr),
    .busy(b16), .done(d16), .count(c16), .cfg_addr(a16), .cfg_read(r16),
    .cfg_write(w16), .cfg_wdata(wd16), .cfg_rdata(rd16), .cfg_waitreq(wt16));
  crc_errcnt_seq #(.LANES(8)) u_crc_errcnt_seq_x8 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_ecrc(sel), .clr_req(clr),
    .busy(b8), .done(d8), .count(c8), .cfg_addr(a8), .cfg_read(r8),
    .cfg_write(w8), .cfg_wdata(wd8), .cfg_rdata(rd8), .cfg_waitreq(wt8));
  crc_errcnt_seq #(.LANES(4)) u_crc_errcnt_seq_x4 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_ecrc(sel), .clr_req(clr),
    .busy(b4), .done(d4), .count(c4), .cfg_addr(a4), .cfg_read(r4),
    .cfg_write(w4), .cfg_wdata(wd4), .cfg_rdata(rd4), .cfg_waitreq(wt4));

  crc_cfg_model m16 (.clk(clk), .rst_n(rst_n), .cfg_read(r16), .cfg_write(w16),
    .cfg_addr(a16), .cfg_wdata(wd16), .cfg_rdata(rd16), .cfg_waitreq(wt16),
    .pre_en(pre_en), .pre_addr(pre_addr), .pre_data(pre_data), .log_clr(log_clr));
  crc_cfg_model m8 (.clk(clk), .rst_n(rst_n), .cfg_read(r8), .cfg_write(w8),
    .cfg_addr(a8), .cfg_wdata(wd8), .cfg_rdata(rd8), .cfg_waitreq(wt8),
    .pre_en(pre_en), .pre_addr(pre_addr), .pre_data(pre_data), .log_clr(log_clr));
  crc_cfg_model m4 (.clk(clk), .rst_n(rst_n), .cfg_read(r4), .cfg_write(w4),
    .cfg_addr(a4), .cfg_wdata(wd4), .cfg_rdata(rd4), .cfg_waitreq(wt4),
    .pre_en(pre_en), .pre_addr(pre_addr), .pre_data(pre_data), .log_clr(log_clr));

  always @(posedge clk) begin
    if (d16) dn16++;
    if (d8)  dn8++;
    if (d4)  dn4++;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic load_count(input logic [31:0] base, input logic [31:0] v);
    for (int i = 0; i < 4; i++) preload(base + 32'd4 + 32'(i), v[i*8 +: 8]);
  endtask

  task automatic fire(input logic s, input logic c);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; dn16 = 0; dn8 = 0; dn4 = 0;
    sel = s; clr = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", "busy after start", 32'(b16), 32'd1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while ((b16 || b8 || b4) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) begin
      checks++; errors++;
      $display("FAIL R9 run timeout: actual busy 1 expected 0");
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_seq(input logic [31:0] base, input logic [7:0] g,
                           input logic [7:0] e, input logic [7:0] chk_b,
                           input logic [7:0] en_b);
    check("R2", "write count", 32'(m16.wr_n), 32'd5);
    check("R2", "wr0 addr", m16.wr_addr[0], 32'h119);
    check("R2", "wr1 addr", m16.wr_addr[1], base + 32'd3);
    check("R2", "wr2 addr", m16.wr_addr[2], base + 32'd2);
    check("R2", "wr3 addr", m16.wr_addr[3], base + 32'd1);
    check("R2", "wr4 addr", m16.wr_addr[4], base);
    check("R2", "read count", 32'(m16.rd_n), 32'd9);
    for (int i = 0; i < 4; i++)
      check("R2", "count read addr", m16.rd_addr[5+i], base + 32'd4 + 32'(i));
    check("R3", "check enable byte", 32'(m16.wr_data[0]), 32'(chk_b));
    check("R4", "group byte", 32'(m16.wr_data[1]), 32'(g));
    check("R4", "event byte", 32'(m16.wr_data[2]), 32'(e));
    check("R4", "reserved byte", 32'(m16.wr_data[3]), 32'h00);
    check("R6", "enable byte", 32'(m16.wr_data[4]), 32'(en_b));
    check("R5", "read-before-write", 32'(m16.rmw_err), 32'd0);
    check("R8", "hold under wait", 32'(m16.stab_err), 32'd0);
    check("R9", "done pulses", 32'(dn16), 32'd1);
  endtask

  task automatic t_reset();
    check("R1", "busy", 32'(b16), 32'd0);
    check("R1", "done", 32'(d16), 32'd0);
    check("R1", "count", c16, 32'd0);
    check("R1", "read/write", {30'd0, r16, w16}, 32'd0);
  endtask

  task automatic t_lcrc();
    preload(32'h119, 8'hA4);
    preload(B16, 8'h81); preload(B16 + 32'd1, 8'h55);
    preload(B16 + 32'd2, 8'hEE); preload(B16 + 32'd3, 8'hEE);
    load_count(B16, 32'h7856_3412);
    load_count(B8,  32'hA1B2_C3D4);
    load_count(B4,  32'h0BAD_F00D);
    fire(1'b0, 1'b0);
    wait_idle();
    check_seq(B16, 8'h02, 8'h01, 8'hA5, 8'h9D);
    check("R7", "x16 count", c16, 32'h7856_3412);
    check("R2", "x8 group addr", m8.wr_addr[1], B8 + 32'd3);
    check("R7", "x8 count", c8, 32'hA1B2_C3D4);
    check("R2", "x4 group addr", m4.wr_addr[1], B4 + 32'd3);
    check("R7", "x4 count", c4, 32'h0BAD_F00D);
    check("R5", "x4 read-before-write", 32'(m4.rmw_err), 32'd0);
  endtask

  task automatic t_ecrc_clear();
    preload(32'h119, 8'h10);
    preload(B16, 8'h81);
    load_count(B16, 32'hCAFE_0001);
    fire(1'b1, 1'b1);
    check("R7", "count cleared at start", c16, 32'd0);
    wait_idle();
    check_seq(B16, 8'h03, 8'h02, 8'h11, 8'h9F);
    check("R7", "x16 count ecrc", c16, 32'hCAFE_0001);
  endtask

  task automatic t_busy_start();
    preload(32'h119, 8'h00);
    preload(B16, 8'h81);
    load_count(B16, 32'h0000_0042);
    fire(1'b0, 1'b0);
    repeat (6) @(negedge clk);
    sel = 1'b1; clr = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (40) @(negedge clk);
    check("R10", "busy after ignored start", 32'(b16), 32'd0);
    check("R10", "writes in one run", 32'(m16.wr_n), 32'd5);
    check("R10", "group keeps first sel", 32'(m16.wr_data[1]), 32'h02);
    check("R10", "enable keeps first clr", 32'(m16.wr_data[4]), 32'h9D);
    check("R10", "done pulses", 32'(dn16), 32'd1);
    check("R7", "count", c16, 32'h0000_0042);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lcrc();
    t_ecrc_clear();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule